// File: doc/BRIEF.md
# Four-Register Datapath with Function Unit

This block is the execution datapath of a small processor. It holds four parallel-load registers. Each cycle, one register is placed on bus A and another on bus B. A function unit transforms the two buses, and the result, or a word from outside, can be written back into one register at the next clock edge. A single flat control word, supplied by an external sequencer, drives every multiplexer select and the write. Instruction decoding and memory are outside the block.

Bus A always leaves the block as an address output, and bus B leaves as a data output. A cycle that has its load bit cleared can therefore present an address or a store value without disturbing any register. The function unit has three parts:

- an adder whose second operand is shaped by two select bits and a carry-in;
- a bitwise logic unit;
- a shifter acting on bus B.

Four status flags describe the function result of the current cycle. All paths from the control word to the outputs are combinational. The registers are the only state. Data moves every cycle under the control word, so the block has no valid/ready handshake and no back-pressure: the sequencer owns all timing.

Top module: `dp_top`

## Requirements
- R1: An active-low asynchronous reset clears all four registers to zero, so any A or B selection reads 0 after reset.
- R2: The control word is 14 bits. The fields are:
  - bits 1:0: destination register;
  - bits 3:2: A-select;
  - bits 5:4: B-select;
  - bit 6: const-on-B;
  - bits 10:7: function code;
  - bit 11: shift-select;
  - bit 12: external-data select;
  - bit 13: load.

  `addr_out` shows the register chosen by A-select. `data_out` shows the register chosen by B-select, or `const_in` when const-on-B is 1.
- R3: When shift-select is 0 and function code bit 3 is 0, the result is A + Y + code[0]. Y is chosen by code[2:1]:
  - 00: zero;
  - 01: B;
  - 10: bitwise NOT of B;
  - 11: all ones.
- R4: When shift-select is 0 and function code bit 3 is 1, code[1:0] selects the operation: 00 is A AND B, 01 is A OR B, 10 is A XOR B, and 11 is NOT A.
- R5: When shift-select is 1, code[1:0] selects the operation on bus B, with zero fill: 00 passes B, 01 is a logical shift right by one, 10 is a logical shift left by one, and 11 passes B.
- R6: At a rising clock edge with load = 1, the destination register takes `ext_in` when external-data select is 1, and the function result otherwise. No other register changes.
- R7: With load = 0, no register changes, whatever the other fields hold.
- R8: `flag_z` is 1 exactly when the function result is zero. `flag_n` equals the result's MSB. Both describe the function result even when external data is being written.
- R9: `flag_c` is the adder carry-out. `flag_v` is 1 when A and Y have equal signs and the sum's sign differs from them. Both flags are 0 for logic and shift operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 14 | Control word (layout in R2) |
| const_in | input | 8 | Constant that can replace the B register |
| ext_in | input | 8 | External data that can be written to a register |
| addr_out | output | 8 | Bus A |
| data_out | output | 8 | Bus B |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result MSB |
| flag_z | output | 1 | Result is zero |

## Verification
The registers are the only state. A wrong register value, such as a write to the wrong destination, a write while load is low, or a missing reset, stays hidden until a later control word selects that register onto bus A or bus B. It then shows on `addr_out` or `data_out` in that same cycle. The bench therefore reads back every register after each group of writes and after load-low cycles. A fault in a multiplexer select or in the function unit is combinational, and it appears on the buses and flags in the very cycle its control word is applied.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int NREG = 4;
  localparam int SELW = $clog2(NREG);
  localparam int FSW  = 4;

  typedef struct packed {
    logic            load;
    logic            ext_sel;
    logic            shift_sel;
    logic [FSW-1:0]  fsel;
    logic            const_b;
    logic [SELW-1:0] bsel;
    logic [SELW-1:0] asel;
    logic [SELW-1:0] dst;
  } ctl_t;

  localparam int CTLW = $bits(ctl_t);

  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_SRL   = 2'b01,
    SH_SLL   = 2'b10,
    SH_PASS2 = 2'b11
  } shop_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W    = 8,
  parameter int N    = 4,
  localparam int SW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rda_sel,
  input  logic [SW-1:0] rdb_sel,
  output logic [W-1:0]  rda,
  output logic [W-1:0]  rdb
);
  logic [W-1:0] regs [N];
  logic [N-1:0] wr_dec;

  always_comb begin
    wr_dec = '0;
    if (wr_en) wr_dec[wr_sel] = 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs[i] <= '0;
      else if (wr_dec[i]) regs[i] <= wr_data;
    end

    // R6: a decoded write lands the presented data
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SW'(i)) |=> (regs[i] == $past(wr_data)));

    // R7: without a write aimed here the register keeps its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SW'(i)) |=> $stable(regs[i]));
  end

  assign rda = regs[rda_sel];
  assign rdb = regs[rdb_sel];
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W   = 8,
  parameter int FSW = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [FSW-1:0] fsel,
  output logic [W-1:0]   y,
  output logic           c,
  output logic           v
);
  logic [W-1:0] opnd;
  logic [W:0]   sum;
  logic [W-1:0] lres;
  logic         is_logic;

  assign is_logic = fsel[3];

  always_comb begin
    unique case (fsel[2:1])
      2'b00:   opnd = '0;
      2'b01:   opnd = b;
      2'b10:   opnd = ~b;
      default: opnd = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, opnd} + {{W{1'b0}}, fsel[0]};

  always_comb begin
    unique case (fsel[1:0])
      2'b00:   lres = a & b;
      2'b01:   lres = a | b;
      2'b10:   lres = a ^ b;
      default: lres = ~a;
    endcase
  end

  assign y = is_logic ? lres : sum[W-1:0];
  assign c = is_logic ? 1'b0 : sum[W];
  assign v = is_logic ? 1'b0 :
             ((a[W-1] == opnd[W-1]) && (sum[W-1] != a[W-1]));

  // R9: overflow needs like-signed operands
  always_comb begin
    if (v) p_v_needs_same_sign_r9: assert (a[W-1] == opnd[W-1]);
  end
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] y
);
  import dp_pkg::*;

  always_comb begin
    unique case (shop_e'(op))
      SH_SRL:  y = {1'b0, b[W-1:1]};
      SH_SLL:  y = {b[W-2:0], 1'b0};
      default: y = b;
    endcase
  end

  // R5: zero fill on the vacated end
  always_comb begin
    if (op == 2'b01) p_srl_fill_r5: assert (y[W-1] == 1'b0 && y[W-2:0] == b[W-1:1]);
    if (op == 2'b10) p_sll_fill_r5: assert (y[0] == 1'b0 && y[W-1:1] == b[W-2:0]);
  end
endmodule

// File: rtl/dp_top.sv
module dp_top #(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [dp_pkg::CTLW-1:0] ctl_word,
  input  logic [W-1:0]            const_in,
  input  logic [W-1:0]            ext_in,
  output logic [W-1:0]            addr_out,
  output logic [W-1:0]            data_out,
  output logic                    flag_v,
  output logic                    flag_c,
  output logic                    flag_n,
  output logic                    flag_z
);
  import dp_pkg::*;

  ctl_t         cw;
  logic [W-1:0] rda, rdb, bus_b;
  logic [W-1:0] alu_y, sh_y, func_y, wr_data;
  logic         alu_c, alu_v;

  assign cw = ctl_t'(ctl_word);

  dp_regfile #(.W(W), .N(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cw.load),
    .wr_sel  (cw.dst),
    .wr_data (wr_data),
    .rda_sel (cw.asel),
    .rdb_sel (cw.bsel),
    .rda     (rda),
    .rdb     (rdb)
  );

  assign bus_b = cw.const_b ? const_in : rdb;

  dp_alu #(.W(W), .FSW(FSW)) u_alu (
    .a    (rda),
    .b    (bus_b),
    .fsel (cw.fsel),
    .y    (alu_y),
    .c    (alu_c),
    .v    (alu_v)
  );

  dp_shifter #(.W(W)) u_sh (
    .b  (bus_b),
    .op (cw.fsel[1:0]),
    .y  (sh_y)
  );

  assign func_y  = cw.shift_sel ? sh_y : alu_y;
  assign wr_data = cw.ext_sel ? ext_in : func_y;

  assign addr_out = rda;
  assign data_out = bus_b;
  assign flag_z   = (func_y == '0);
  assign flag_n   = func_y[W-1];
  assign flag_c   = cw.shift_sel ? 1'b0 : alu_c;
  assign flag_v   = cw.shift_sel ? 1'b0 : alu_v;

  // R9: carry and overflow stay low outside arithmetic
  always_comb begin
    if (rst_n && (cw.shift_sel || cw.fsel[3]))
      p_no_cv_nonarith_r9: assert (!flag_c && !flag_v);
  end
endmodule

// File: tb/sim_dp_top.sv
module sim_dp_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [13:0]  ctl_word = '0;
  logic [W-1:0] const_in = '0, ext_in = '0;
  logic [W-1:0] addr_out, data_out;
  logic         flag_v, flag_c, flag_n, flag_z;

  always #4 clk = ~clk;

  dp_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
    .const_in(const_in), .ext_in(ext_in),
    .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] d;
    logic [3:0]   f;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] mregs [4];
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  function automatic logic [13:0] mk(bit ld, bit ex, bit sh, logic [3:0] fs,
                                     bit cb, logic [1:0] bs, logic [1:0] as,
                                     logic [1:0] ds);
    return {ld, ex, sh, fs, cb, bs, as, ds};
  endfunction

  // returns {v, c, y} built from R3, R4, R5, R9
  function automatic logic [W+1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [3:0] fs, bit sh);
    logic [W-1:0] y, op;
    logic [W:0]   s;
    logic         v;
    if (sh) begin
      case (fs[1:0])
        2'b01:   y = b >> 1;
        2'b10:   y = b << 1;
        default: y = b;
      endcase
      return {2'b00, y};
    end
    if (fs[3]) begin
      case (fs[1:0])
        2'b00:   y = a & b;
        2'b01:   y = a | b;
        2'b10:   y = a ^ b;
        default: y = ~a;
      endcase
      return {2'b00, y};
    end
    case (fs[2:1])
      2'b00:   op = 0;
      2'b01:   op = b;
      2'b10:   op = ~b;
      default: op = {W{1'b1}};
    endcase
    s = a + op + fs[0];
    v = (a[W-1] == op[W-1]) && (s[W-1] != a[W-1]);
    return {v, s[W], s[W-1:0]};
  endfunction

  task automatic step(logic [13:0] cw, logic [W-1:0] ci, logic [W-1:0] ei, string tag);
    exp_t         e;
    logic [W-1:0] a, b;
    logic [W+1:0] r;
    @(negedge clk);
    #1;
    ctl_word = cw; const_in = ci; ext_in = ei;
    a = mregs[cw[3:2]];
    b = cw[6] ? ci : mregs[cw[5:4]];
    r = model(a, b, cw[10:7], cw[11]);
    e.a = a; e.d = b; e.tag = tag;
    e.f = {r[W+1], r[W], r[W-1], (r[W-1:0] == 0)};
    sb.push_back(e);
    if (cw[13]) mregs[cw[1:0]] = cw[12] ? ei : r[W-1:0];
  endtask

  task automatic readall(string tag);
    for (int i = 0; i < 4; i++)
      step(mk(0, 0, 1, 4'b0000, 0, 2'(i), 2'(i), 2'(i)), 8'h00, 8'h00, tag);
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (addr_out !== e.a || data_out !== e.d ||
            {flag_v, flag_c, flag_n, flag_z} !== e.f) begin
          n_bad++;
          $display("FAIL %s: got a=%h d=%h vcnz=%b exp a=%h d=%h vcnz=%b",
                   e.tag, addr_out, data_out, {flag_v, flag_c, flag_n, flag_z},
                   e.a, e.d, e.f);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    readall("R1 reset value");

    // R2/R6: load constants through the shifter pass path
    step(mk(1, 0, 1, 4'b0000, 1, 0, 0, 0), 8'h5A, 8'h00, "R6 load const r0");
    step(mk(1, 0, 1, 4'b0011, 1, 0, 0, 1), 8'h81, 8'h00, "R5 pass2 load r1");
    step(mk(1, 0, 1, 4'b0000, 1, 0, 0, 2), 8'h7F, 8'h00, "R6 load const r2");
    step(mk(1, 1, 0, 4'b0010, 0, 1, 0, 3), 8'h00, 8'h01, "R8 flags while ext write r3");
    readall("R2 read back after loads");

    // R3: all arithmetic codes over two register pairs
    for (int f = 0; f < 8; f++) begin
      step(mk(0, 0, 0, 4'(f), 0, 3, 2, 0), 8'h00, 8'h00, "R3 arith r2,r3");
      step(mk(0, 0, 0, 4'(f), 0, 1, 0, 0), 8'h00, 8'h00, "R3 arith r0,r1");
    end
    // R9: signed overflow and carry corners
    step(mk(0, 0, 0, 4'b0010, 0, 3, 2, 0), 8'h00, 8'h00, "R9 7F+01 overflow");
    step(mk(0, 0, 0, 4'b0010, 0, 1, 1, 0), 8'h00, 8'h00, "R9 81+81 carry overflow");
    step(mk(0, 0, 0, 4'b0101, 0, 0, 0, 0), 8'h00, 8'h00, "R8 A-A zero flag");
    // R4: logic ops, with const on B
    for (int f = 8; f < 12; f++) begin
      step(mk(0, 0, 0, 4'(f), 0, 1, 0, 0), 8'h00, 8'h00, "R4 logic r0,r1");
      step(mk(0, 0, 0, 4'(f | 4), 1, 0, 2, 0), 8'hF0, 8'h00, "R4 logic const");
    end
    // R5: shifter on register and on const
    for (int f = 0; f < 4; f++) begin
      step(mk(0, 0, 1, 4'(f), 0, 1, 0, 0), 8'h00, 8'h00, "R5 shift r1");
      step(mk(0, 0, 1, 4'(f | 8), 1, 0, 0, 0), 8'h01, 8'h00, "R5 shift const");
    end
    // R6: arithmetic and shift results written back
    step(mk(1, 0, 0, 4'b0011, 0, 3, 2, 1), 8'h00, 8'h00, "R6 write A+B+1");
    step(mk(1, 0, 1, 4'b0010, 0, 0, 0, 2), 8'h00, 8'h00, "R6 write sll");
    step(mk(1, 1, 0, 4'b1011, 0, 0, 0, 0), 8'h00, 8'hA5, "R6 write ext");
    readall("R6 read back after writes");
    // R7: load low with every other field busy
    step(mk(0, 1, 0, 4'b0011, 0, 3, 2, 1), 8'h00, 8'hEE, "R7 no load ext");
    step(mk(0, 0, 1, 4'b0010, 1, 0, 0, 3), 8'hFF, 8'h00, "R7 no load func");
    readall("R7 read back unchanged");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule